// File: doc/BRIEF.md
# Serial Bus Address and Direction Status Tracker

This block listens to a two-wire serial bus (I2C) whose clock and data lines have already been brought into the system clock domain. It finds start and stop conditions and counts clock pulses from each start. It also collects the first byte after a start, which carries a 7-bit address and a direction bit. From these bus events and a few control strobes it keeps three status flags for a host to read. The first flag marks a reserved extension address. The second marks a match with the local slave address. The third says whether the local side is the transmitter.

The block serves as either a bus master or a bus slave, chosen by a role input. A fourth output enables the data-line driver. It turns on only when the local side is the transmitter and the acknowledge clock of the first byte has begun.

Top module: `addr_dir_status_tracker`

## Requirements
- R1: A start is the data line falling while the clock line is high, and a stop is the data line rising while the clock line is high. Both are taken from registered samples, and a start resets the bit count. A line change reaches the flags on the second rising system clock edge after it. After reset all four outputs are 0.
- R2: On the 8th rising bus clock after a start, `ext_code_o` is set if address bits [6:3] are 0000 or 1111. The address is received most significant bit first on rising edges 1 to 7.
- R3: On that same 8th rising edge, `addr_match_o` is set when the received 7-bit address equals `own_addr_i`.
- R4: `ext_code_o` and `addr_match_o` are cleared by a detected start, a detected stop, a `release_i` pulse, or `iface_en_i` falling from 1 to 0.
- R5: In master role (`master_mode_i`=1), a `master_start_i` pulse sets `xmit_o`. A start detected on the bus does not clear it.
- R6: In master role, `xmit_o` is cleared on the 8th rising edge of the first byte when `sda_drv_i` (the value driven as the direction bit) is 1.
- R7: In slave role (`master_mode_i`=0), `xmit_o` is set on the 8th rising edge when the received direction bit is 1. It is cleared by a detected start.
- R8: `xmit_o` is cleared in either role by:
  - a stop;
  - a `release_i` pulse;
  - a `wait_rel_i` pulse;
  - `arb_lost_i` rising from 0 to 1;
  - `iface_en_i` falling.
- R9: `sda_oe_o` is 1 only while `xmit_o` is 1 and the 9th rising edge of the first byte has happened since the last start. When `xmit_o` clears, `sda_oe_o` drops in the same cycle.
- R10: When a set and a clear condition of a flag occur in the same cycle, the flag ends up 0.
- R11: Only the first byte after a start can set a flag; later bus clocks leave all flags unchanged. While `iface_en_i` is 0, no flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| scl_i | input | 1 | Synchronized bus clock line |
| sda_i | input | 1 | Synchronized bus data line |
| own_addr_i | input | ADDR_W | Local slave address |
| iface_en_i | input | 1 | Interface enable level |
| master_mode_i | input | 1 | 1 = master role, 0 = slave role |
| master_start_i | input | 1 | Pulse: local side generated a start |
| sda_drv_i | input | 1 | Value the local side drives on the data line |
| release_i | input | 1 | Pulse: release from communication |
| wait_rel_i | input | 1 | Pulse: wait release |
| arb_lost_i | input | 1 | Arbitration-lost indication |
| ext_code_o | output | 1 | Extension-code address received |
| addr_match_o | output | 1 | Local address matched |
| xmit_o | output | 1 | Local side is transmitter |
| sda_oe_o | output | 1 | Data-line driver enable |

## Verification
The bench builds the block with its default parameters:
- a 7-bit address;
- a 4-bit extension nibble with the nibble check generated in;
- a two-stage sampler.

With these values the all-zero and all-one nibble addresses, the local address `0x3A` and a non-matching address can be driven one after another. The bench also covers repeated starts, a second byte and the acknowledge clock. Both roles are exercised, along with each clear strobe on its own and clears that coincide with sets.

// File: rtl/adst_pkg.sv
package adst_pkg;

   typedef enum logic {
      ROLE_SLAVE  = 1'b0,
      ROLE_MASTER = 1'b1
   } role_e;

   typedef struct packed {
      logic start;
      logic stop;
      logic scl_rise;
   } bus_evt_t;

endpackage

// File: rtl/adst_line_events.sv
module adst_line_events
   import adst_pkg::*;
#(
   parameter int SAMPLE_DEPTH = 2
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     scl_i,
   input  logic     sda_i,
   output bus_evt_t evt_o,
   output logic     sda_bit_o
);
   localparam int NEW_IDX = SAMPLE_DEPTH - 2;
   localparam int OLD_IDX = SAMPLE_DEPTH - 1;

   // each stage holds {scl, sda}; idle bus is high on both lines
   logic [SAMPLE_DEPTH-1:0][1:0] pipe_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pipe_q <= '1;
      end else begin
         pipe_q <= {pipe_q[SAMPLE_DEPTH-2:0], {scl_i, sda_i}};
      end
   end

   logic scl_new, sda_new, scl_old, sda_old;
   assign scl_new = pipe_q[NEW_IDX][1];
   assign sda_new = pipe_q[NEW_IDX][0];
   assign scl_old = pipe_q[OLD_IDX][1];
   assign sda_old = pipe_q[OLD_IDX][0];

   always_comb begin
      evt_o.start    = scl_new & scl_old & sda_old & ~sda_new;
      evt_o.stop     = scl_new & scl_old & ~sda_old & sda_new;
      evt_o.scl_rise = scl_new & ~scl_old;
   end

   assign sda_bit_o = sda_new;

endmodule

// File: rtl/adst_first_byte.sv
module adst_first_byte
   import adst_pkg::*;
#(
   parameter int ADDR_W = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  bus_evt_t          evt_i,
   input  logic              sda_bit_i,
   output logic [ADDR_W-1:0] addr_o,
   output logic              dir_bit_o,
   output logic              addr_ready_o,
   output logic              ack_rise_o
);
   localparam int CNT_W = $clog2(ADDR_W + 3);
   localparam logic [CNT_W-1:0] DIR_POS = CNT_W'(ADDR_W);
   localparam logic [CNT_W-1:0] ACK_POS = CNT_W'(ADDR_W + 1);

   logic [CNT_W-1:0]  cnt_q;
   logic [ADDR_W-1:0] shreg_q;
   logic              in_first_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q      <= '0;
         shreg_q    <= '0;
         in_first_q <= 1'b0;
      end else if (evt_i.start) begin
         cnt_q      <= '0;
         in_first_q <= 1'b1;
      end else if (evt_i.stop) begin
         in_first_q <= 1'b0;
      end else if (evt_i.scl_rise && in_first_q) begin
         if (cnt_q < DIR_POS) begin
            shreg_q <= {shreg_q[ADDR_W-2:0], sda_bit_i};
         end
         if (cnt_q == ACK_POS) begin
            in_first_q <= 1'b0;
         end
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign addr_o       = shreg_q;
   assign dir_bit_o    = sda_bit_i;
   assign addr_ready_o = evt_i.scl_rise & in_first_q & (cnt_q == DIR_POS);
   assign ack_rise_o   = evt_i.scl_rise & in_first_q & (cnt_q == ACK_POS);

   assert_cnt_restart_R1: assert property (@(posedge clk) disable iff (!rst_n)
      evt_i.start |=> (cnt_q == '0));

endmodule

// File: rtl/adst_status_flags.sv
module adst_status_flags
   import adst_pkg::*;
#(
   parameter int ADDR_W       = 7,
   parameter int EXT_W        = 4,
   parameter bit EXT_CHECK_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              stop_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              dir_bit_i,
   input  logic              addr_ready_i,
   input  logic              ack_rise_i,
   input  logic [ADDR_W-1:0] own_addr_i,
   input  logic              iface_en_i,
   input  logic              master_mode_i,
   input  logic              master_start_i,
   input  logic              sda_drv_i,
   input  logic              release_i,
   input  logic              wait_rel_i,
   input  logic              arb_lost_i,
   output logic              ext_code_o,
   output logic              addr_match_o,
   output logic              xmit_o,
   output logic              sda_oe_o
);
   role_e role;
   assign role = role_e'(master_mode_i);

   logic en_q, arb_q;
   logic ext_q, match_q, trc_q, ninth_q;
   logic en_fall, arb_rise, ext_hit;

   generate
      if (EXT_CHECK_EN) begin : g_ext_on
         logic [EXT_W-1:0] nib;
         assign nib     = addr_i[ADDR_W-1 -: EXT_W];
         assign ext_hit = (&nib) | ~(|nib);
      end else begin : g_ext_off
         assign ext_hit = 1'b0;
      end
   endgenerate

   assign en_fall  = en_q & ~iface_en_i;
   assign arb_rise = arb_lost_i & ~arb_q;

   logic addr_clr, addr_evt, trc_set, trc_clr, ninth_clr;
   assign addr_clr  = start_i | stop_i | release_i | en_fall;
   assign addr_evt  = addr_ready_i & iface_en_i;
   assign trc_set   = iface_en_i &
                      (((role == ROLE_MASTER) & master_start_i) |
                       ((role == ROLE_SLAVE) & addr_ready_i & dir_bit_i));
   assign trc_clr   = stop_i | release_i | wait_rel_i | arb_rise | en_fall |
                      ((role == ROLE_SLAVE) & start_i) |
                      ((role == ROLE_MASTER) & addr_ready_i & sda_drv_i);
   assign ninth_clr = start_i | stop_i | en_fall;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q    <= 1'b0;
         arb_q   <= 1'b0;
         ext_q   <= 1'b0;
         match_q <= 1'b0;
         trc_q   <= 1'b0;
         ninth_q <= 1'b0;
      end else begin
         en_q  <= iface_en_i;
         arb_q <= arb_lost_i;
         // clear conditions take priority over set conditions
         if (addr_clr)                          ext_q   <= 1'b0;
         else if (addr_evt && ext_hit)          ext_q   <= 1'b1;
         if (addr_clr)                          match_q <= 1'b0;
         else if (addr_evt && addr_i == own_addr_i) match_q <= 1'b1;
         if (trc_clr)                           trc_q   <= 1'b0;
         else if (trc_set)                      trc_q   <= 1'b1;
         if (ninth_clr)                         ninth_q <= 1'b0;
         else if (ack_rise_i && iface_en_i)     ninth_q <= 1'b1;
      end
   end

   assign ext_code_o   = ext_q;
   assign addr_match_o = match_q;
   assign xmit_o       = trc_q;
   assign sda_oe_o     = trc_q & ninth_q;

   assert_start_clears_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> (!ext_code_o && !addr_match_o));

   assert_strobe_clears_trc_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_i || release_i || wait_rel_i) |=> !xmit_o);

   assert_slave_start_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !master_mode_i) |=> !xmit_o);

   assert_ext_only_on_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ext_code_o) |-> $past(addr_ready_i));

   assert_match_only_on_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(addr_match_o) |-> $past(addr_ready_i));

endmodule

// File: rtl/addr_dir_status_tracker.sv
module addr_dir_status_tracker
   import adst_pkg::*;
#(
   parameter int ADDR_W       = 7,
   parameter int EXT_W        = 4,
   parameter bit EXT_CHECK_EN = 1'b1,
   parameter int SAMPLE_DEPTH = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   input  logic [ADDR_W-1:0] own_addr_i,
   input  logic              iface_en_i,
   input  logic              master_mode_i,
   input  logic              master_start_i,
   input  logic              sda_drv_i,
   input  logic              release_i,
   input  logic              wait_rel_i,
   input  logic              arb_lost_i,
   output logic              ext_code_o,
   output logic              addr_match_o,
   output logic              xmit_o,
   output logic              sda_oe_o
);
   generate
      if (ADDR_W < 2) begin : g_bad_addr
         $error("ADDR_W must be at least 2");
      end
      if (EXT_W < 1 || EXT_W > ADDR_W) begin : g_bad_ext
         $error("EXT_W must lie in 1..ADDR_W");
      end
      if (SAMPLE_DEPTH < 2) begin : g_bad_depth
         $error("SAMPLE_DEPTH must be at least 2");
      end
   endgenerate

   bus_evt_t          evt;
   logic              sda_bit;
   logic [ADDR_W-1:0] addr;
   logic              dir_bit, addr_ready, ack_rise;

   adst_line_events #(.SAMPLE_DEPTH(SAMPLE_DEPTH)) u_events (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_i     (scl_i),
      .sda_i     (sda_i),
      .evt_o     (evt),
      .sda_bit_o (sda_bit)
   );

   adst_first_byte #(.ADDR_W(ADDR_W)) u_byte (
      .clk          (clk),
      .rst_n        (rst_n),
      .evt_i        (evt),
      .sda_bit_i    (sda_bit),
      .addr_o       (addr),
      .dir_bit_o    (dir_bit),
      .addr_ready_o (addr_ready),
      .ack_rise_o   (ack_rise)
   );

   adst_status_flags #(
      .ADDR_W       (ADDR_W),
      .EXT_W        (EXT_W),
      .EXT_CHECK_EN (EXT_CHECK_EN)
   ) u_flags (
      .clk            (clk),
      .rst_n          (rst_n),
      .start_i        (evt.start),
      .stop_i         (evt.stop),
      .addr_i         (addr),
      .dir_bit_i      (dir_bit),
      .addr_ready_i   (addr_ready),
      .ack_rise_i     (ack_rise),
      .own_addr_i     (own_addr_i),
      .iface_en_i     (iface_en_i),
      .master_mode_i  (master_mode_i),
      .master_start_i (master_start_i),
      .sda_drv_i      (sda_drv_i),
      .release_i      (release_i),
      .wait_rel_i     (wait_rel_i),
      .arb_lost_i     (arb_lost_i),
      .ext_code_o     (ext_code_o),
      .addr_match_o   (addr_match_o),
      .xmit_o         (xmit_o),
      .sda_oe_o       (sda_oe_o)
   );

endmodule

// File: tb/addr_dir_status_tracker_tb_top.sv
`timescale 1ns/1ps
module addr_dir_status_tracker_tb_top;
   localparam int HOLD = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl = 1'b1, sda = 1'b1;
   logic [6:0] own_addr = 7'h3A;
   logic en = 1'b1, mm = 1'b0, mstart = 1'b0, drv = 1'b0;
   logic rel = 1'b0, wrel = 1'b0, arb = 1'b0;
   logic ext_o, match_o, xmit_o, oe_o;

   always #4 clk = ~clk;

   addr_dir_status_tracker dut_i (
      .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda),
      .own_addr_i(own_addr), .iface_en_i(en), .master_mode_i(mm),
      .master_start_i(mstart), .sda_drv_i(drv), .release_i(rel),
      .wait_rel_i(wrel), .arb_lost_i(arb),
      .ext_code_o(ext_o), .addr_match_o(match_o), .xmit_o(xmit_o),
      .sda_oe_o(oe_o)
   );

   typedef struct {
      logic [3:0] val;
      string      tag;
   } exp_t;

   exp_t exp_q[$];
   int checks = 0;
   int errors = 0;
   bit done = 0;

   // monitor: pops expected items and compares them with the outputs
   initial begin
      forever begin
         exp_t e;
         wait (exp_q.size() > 0);
         e = exp_q.pop_front();
         checks++;
         if ({ext_o, match_o, xmit_o, oe_o} !== e.val) begin
            errors++;
            $display("FAIL %s: {ext,match,xmit,oe} actual %b expected %b",
                     e.tag, {ext_o, match_o, xmit_o, oe_o}, e.val);
         end
      end
   end

   task automatic expect_st(input logic [3:0] v, input string tag);
      exp_t e;
      e.val = v;
      e.tag = tag;
      exp_q.push_back(e);
      #0;
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_start();
      sda = 1'b1; tick(HOLD);
      scl = 1'b1; tick(HOLD);
      sda = 1'b0; tick(HOLD);
      scl = 1'b0; tick(HOLD);
   endtask

   task automatic bus_stop();
      sda = 1'b0; tick(HOLD);
      scl = 1'b1; tick(HOLD);
      sda = 1'b1; tick(HOLD);
   endtask

   task automatic bus_bit(input logic b);
      sda = b; drv = b; tick(HOLD);
      scl = 1'b1; tick(HOLD);
      scl = 1'b0; tick(HOLD);
   endtask

   task automatic send_first(input logic [6:0] a, input logic dir);
      for (int i = 6; i >= 0; i--) bus_bit(a[i]);
      bus_bit(dir);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      tick(3);
      rst_n = 1'b1;
      tick(2);
      expect_st(4'b0000, "R1 reset state");

      // slave, own address, read direction
      bus_start();
      send_first(7'h3A, 1'b1);
      expect_st(4'b0110, "R3 R7 match and slave xmit");
      bus_bit(1'b0);
      expect_st(4'b0111, "R9 oe after ninth clock");
      wrel = 1'b1; tick(1); wrel = 1'b0; tick(1);
      expect_st(4'b0100, "R8 R9 wait release drops xmit and oe");
      bus_stop();
      expect_st(4'b0000, "R4 stop clears match");

      // extension nibble 1111, write
      bus_start();
      send_first(7'h78, 1'b0);
      expect_st(4'b1000, "R2 nibble 1111");
      bus_start();
      expect_st(4'b0000, "R1 R4 repeated start clears");
      send_first(7'h05, 1'b1);
      expect_st(4'b1010, "R2 nibble 0000 with slave read");
      rel = 1'b1; tick(1); rel = 1'b0; tick(1);
      expect_st(4'b0000, "R4 R8 release clears");

      // slave start clears xmit, later bytes ignored
      bus_start();
      send_first(7'h3A, 1'b1);
      expect_st(4'b0110, "R3 R7 set again");
      bus_start();
      expect_st(4'b0000, "R7 slave start clears xmit");
      send_first(7'h55, 1'b0);
      expect_st(4'b0000, "R3 no match for 0x55");
      bus_bit(1'b0);
      send_first(7'h3A, 1'b1);
      expect_st(4'b0000, "R11 second byte ignored");
      bus_stop();

      // interface disabled
      en = 1'b0; tick(2);
      bus_start();
      send_first(7'h3A, 1'b1);
      expect_st(4'b0000, "R11 disabled blocks sets");
      bus_stop();
      en = 1'b1; tick(2);

      // enable fall
      bus_start();
      send_first(7'h3A, 1'b1);
      expect_st(4'b0110, "R3 R7 before enable fall");
      en = 1'b0; tick(2);
      expect_st(4'b0000, "R4 R8 enable fall clears");
      en = 1'b1; tick(2);
      bus_stop();

      // arbitration lost
      bus_start();
      send_first(7'h3A, 1'b1);
      arb = 1'b1; tick(2);
      expect_st(4'b0100, "R8 arbitration lost clears xmit");
      arb = 1'b0;
      bus_stop();
      expect_st(4'b0000, "R4 stop after arb");

      // master role, read direction driven
      mm = 1'b1;
      mstart = 1'b1; tick(1); mstart = 1'b0; tick(1);
      expect_st(4'b0010, "R5 master start sets xmit");
      bus_start();
      expect_st(4'b0010, "R5 bus start keeps master xmit");
      send_first(7'h3A, 1'b1);
      expect_st(4'b0100, "R6 driven direction 1 clears xmit");
      bus_stop();

      // master role, write direction
      mstart = 1'b1; tick(1); mstart = 1'b0; tick(1);
      bus_start();
      send_first(7'h3A, 1'b0);
      expect_st(4'b0110, "R6 driven direction 0 keeps xmit");
      bus_bit(1'b0);
      expect_st(4'b0111, "R9 master oe after ninth clock");
      bus_stop();
      expect_st(4'b0000, "R8 stop clears master");

      // coincident set and clear
      mstart = 1'b1; rel = 1'b1; tick(1); mstart = 1'b0; rel = 1'b0; tick(1);
      expect_st(4'b0000, "R10 release beats master start");
      mstart = 1'b1; wrel = 1'b1; tick(1); mstart = 1'b0; wrel = 1'b0; tick(1);
      expect_st(4'b0000, "R10 wait release beats master start");
      mm = 1'b0;

      tick(4);
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule